// File: doc/BRIEF.md
# Three-Phase Inverter Deadtime Generator

This block turns three single-bit phase commands into three complementary drive pairs for the upper and lower switches of a three-phase inverter bridge. Whenever a phase command changes level, the output that was on turns off at once. The opposite output turns on only after a fixed non-overlap interval, and both outputs of that phase stay low for the whole interval. Each phase has its own deadtime counter. That counter also rejects short pulses on the command input: a level that does not stay steady for the whole interval never reaches a switch, and it restarts the interval.

Each phase command passes through a two-stage synchronizer before it reaches the counter, so commands may be asynchronous to the clock. A per-phase enable and a global output enable gate the registered drive signals combinationally. They work without the clock, and when an enable is raised the counter's present result appears at the pins at once. There is no data stream here: every pin is a plain level-sensitive control or drive line, so no valid/ready handshake is involved.

Top module: `three_phase_deadtime`

## Requirements
- R1: In steady state, `drv_hi[i]` equals the level of `ph_cmd[i]` and `drv_lo[i]` is its complement. A command level first sampled at clock edge k turns the new-side output on at edge k+10, provided the command held that level at every edge from k to k+8.
- R2: On a command change first sampled at edge k, the old-side output goes low at edge k+2. The new-side output rises exactly 8 clock periods later, and both outputs of that phase stay low in between.
- R3: While `ph_en[i]` is 0, `drv_hi[i]` and `drv_lo[i]` are both 0, whatever the clock is doing.
- R4: While `out_en` is 0, all six drive outputs are 0, whatever the clock is doing.
- R5: When `ph_en[i]` or `out_en` returns to 1, the phase outputs immediately show the state that phase's counter holds at that moment. That is the settled level if the count has completed, and both low if the count is still running.
- R6: While `rst_n` is 0, all outputs are 0 and all state is cleared asynchronously. After release, no output rises before the 8th clock edge. A command held at 0 from reset turns `drv_lo` on at edge 8. A command held at 1 turns `drv_hi` on at edge 11.
- R7: A command pulse shorter than 8 synchronized cycles never turns on the opposite output. The original output goes low and returns 8 cycles after the pulse ends, so the noise lengthens the low interval.
- R8: Activity on one phase's command or enable never changes the outputs of another phase.
- R9: `drv_hi[i]` and `drv_lo[i]` are never both 1, including across enable changes and reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the deadtime count |
| rst_n | input | 1 | Active-low reset, asynchronous on assertion |
| ph_cmd | input | 3 | Per-phase switch command, 1 selects the upper switch |
| ph_en | input | 3 | Per-phase enable; 0 forces that pair low |
| out_en | input | 1 | Global enable; 0 forces all pairs low |
| drv_hi | output | 3 | Upper switch drive per phase |
| drv_lo | output | 3 | Lower switch drive per phase |

## Verification
The assertions check the following on every cycle: no pair is ever high on both sides, inside the phase or at the pins. A change of the synchronized command clears the pair on the next edge. Every rising output was preceded by exactly the full low interval. A new output level agrees with the command sampled before it. Only the bench scenarios can show the absolute latency from a pin change to a rising output, pulse rejection for each width from 1 to 12 cycles, that gating is immediate and clockless, the counter state that appears when an enable is raised, and the count behaviour after reset release. The bench compares every output against a sliding-window model of the sampled commands.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DT_CYCLES  = 8;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } dtg_pair_t;

  function automatic int cnt_width(input int cycles);
    return $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dtg_phase.sv
module dtg_phase
  import dtg_pkg::*;
#(
  parameter int DEAD = 8,
  parameter int CW   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_s,
  output dtg_pair_t pair_q
);
  localparam logic [CW-1:0] FULL = CW'(DEAD);
  localparam logic [CW-1:0] LAST = CW'(DEAD - 1);

  logic          tgt;
  logic [CW-1:0] cnt;

  // The counter restarts on every change of the sampled command and sets the
  // selected side only after DEAD steady cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt    <= 1'b0;
      cnt    <= '0;
      pair_q <= '0;
    end else if (cmd_s != tgt) begin
      tgt    <= cmd_s;
      cnt    <= '0;
      pair_q <= '0;
    end else if (cnt != FULL) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        pair_q.hi <= tgt;
        pair_q.lo <= ~tgt;
      end
    end
  end

  // Checker state: the number of cycles both outputs have been low, saturating.
  logic [CW-1:0] idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle <= '0;
    else if (pair_q.hi | pair_q.lo) idle <= '0;
    else if (idle != FULL)         idle <= idle + 1'b1;
  end

  AST_PAIR_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_q.hi && pair_q.lo)); // R9

  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s != tgt) |=> (!pair_q.hi && !pair_q.lo)); // R2

  AST_FULL_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_q.hi) |-> (idle == FULL)); // R2

  AST_FULL_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_q.lo) |-> (idle == FULL)); // R7

  AST_HI_MATCHES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_q.hi) |-> $past(cmd_s)); // R1

  AST_LO_MATCHES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_q.lo) |-> !$past(cmd_s)); // R1
endmodule

// File: rtl/three_phase_deadtime.sv
module three_phase_deadtime
  import dtg_pkg::*;
#(
  parameter int N_PH = 3,
  parameter int DEAD = DT_CYCLES,
  parameter int SYNC = SYNC_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] ph_cmd,
  input  logic [N_PH-1:0] ph_en,
  input  logic            out_en,
  output logic [N_PH-1:0] drv_hi,
  output logic [N_PH-1:0] drv_lo
);
  localparam int CW = cnt_width(DEAD);

  for (genvar i = 0; i < N_PH; i++) begin : g_ph
    logic      cmd_s;
    dtg_pair_t pq;

    dtg_sync #(.STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ph_cmd[i]),
      .q    (cmd_s)
    );

    dtg_phase #(.DEAD(DEAD), .CW(CW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_s (cmd_s),
      .pair_q(pq)
    );

    // Gating is combinational so it acts without the clock.
    assign drv_hi[i] = pq.hi & ph_en[i] & out_en;
    assign drv_lo[i] = pq.lo & ph_en[i] & out_en;

    AST_PIN_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_hi[i] && drv_lo[i])); // R9
  end
endmodule

// File: tb/test_three_phase_deadtime.sv
module test_three_phase_deadtime;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd, en, hi, lo;
  logic       oe;

  always #2 clk = ~clk;

  three_phase_deadtime i_three_phase_deadtime (
    .clk   (clk),
    .rst_n (rst_n),
    .ph_cmd(cmd),
    .ph_en (en),
    .out_en(oe),
    .drv_hi(hi),
    .drv_lo(lo)
  );

  int          checks = 0;
  int          errors = 0;
  string       tag = "R6";
  int          act = -1;
  logic [15:0] hist [3];
  int          cyc;

  // Command history sampled at each edge; bit j holds the sample j edges ago.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) hist[i] <= '0;
      cyc <= 0;
    end else begin
      for (int i = 0; i < 3; i++) hist[i] <= {hist[i][14:0], cmd[i]};
      if (cyc < 255) cyc <= cyc + 1;
    end
  end

  // A side is on when the samples 2..10 edges back all hold its level.
  function automatic logic steady(input logic [15:0] h, input logic lvl);
    for (int j = 2; j <= 10; j++) if (h[j] != lvl) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_now();
    for (int p = 0; p < 3; p++) begin
      logic  eh, el;
      string t;
      eh = (cyc >= 8) && steady(hist[p], 1'b1) && en[p] && oe;
      el = (cyc >= 8) && steady(hist[p], 1'b0) && en[p] && oe;
      t  = (act < 0 || p == act) ? tag : "R8";
      checks++;
      if (hi[p] !== eh || lo[p] !== el) begin
        errors++;
        $display("FAIL %s phase %0d at %0t: hi/lo=%b%b expected %b%b",
                 t, p, $time, hi[p], lo[p], eh, el);
      end
      checks++;
      if (hi[p] === 1'b1 && lo[p] === 1'b1) begin
        errors++;
        $display("FAIL R9 phase %0d at %0t: hi/lo=11 expected not both high", p, $time);
      end
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1;
    check_now();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run not finished, expected finish before timeout");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd = 3'b010; en = 3'b111; oe = 1'b1;
    tag = "R6"; act = -1;
    #1 check_now();                       // R6 reset state
    wait_cyc(3);
    rst_n = 1'b1;                         // R6 count after release
    wait_cyc(20);

    // R1, R2, R7: pulse width sweep on each phase, both polarities
    for (int p = 0; p < 3; p++)
      for (int lvl = 0; lvl < 2; lvl++)
        for (int w = 1; w <= 12; w++) begin
          act = p; tag = "R1";
          cmd[p] = lvl[0];
          wait_cyc(14);
          tag = (w < 8) ? "R7" : "R2";
          cmd[p] = ~lvl[0];
          wait_cyc(w);
          cmd[p] = lvl[0];
          wait_cyc(14);
        end

    // R3, R5: phase enable dropped at each point of the count
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 12; k++) begin
        act = p; tag = "R3";
        cmd[p] = ~cmd[p];
        wait_cyc(k);
        en[p] = 1'b0;
        #1 check_now();
        wait_cyc(3);
        tag = "R5";
        en[p] = 1'b1;
        #1 check_now();
        wait_cyc(12);
      end

    // R4, R5: global enable
    for (int k = 0; k < 12; k++) begin
      act = -1; tag = "R4";
      cmd = ~cmd;
      wait_cyc(k);
      oe = 1'b0;
      #1 check_now();
      wait_cyc(2);
      tag = "R5";
      oe = 1'b1;
      #1 check_now();
      wait_cyc(12);
    end

    // R6: reset in mid-run with mixed levels
    act = -1; tag = "R6";
    cmd = 3'b101;
    wait_cyc(15);
    rst_n = 1'b0;
    #1 check_now();
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(20);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule